// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Unit

This block is the sending side of an inter-processor interrupt inside one core's local interrupt controller. Software first places a destination byte in the high command word. It then writes the low command word, which carries the vector, the delivery mode, the addressing mode, the level and trigger flags and a two-bit shorthand. The low-word write launches the send. In that same cycle the block turns the destination into a one-hot-per-core target mask, and it raises a busy flag that software can read back.

The target mask covers up to `NCORE` cores. It can come from a physical ID compare, from a flat-model logical bitmask matched against each core's logical ID, or from a shorthand that ignores the destination byte. The message is offered on a valid/ready output and held steady until the receiver takes it. The busy flag then drops. A new launch is refused while the busy flag is set.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset `msg_valid` is 0, and both command words read back as 0.
- R2: A write to the high word at byte offset 0x310 stores bits 31:24 as the destination byte. Reading offset 0x310 returns that byte in bits 31:24 with every other bit 0.
- R3: A low-word write at offset 0x300 while idle raises `msg_valid` in the following cycle. `msg_vector` comes from bits 7:0, `msg_mode` from bits 10:8 (0 fixed, 1 lowest priority, 2 system management, 4 NMI, 5 INIT, 6 startup), `msg_level` from bit 14 and `msg_trig` from bit 15. `msg_valid` rises only after such a write.
- R4: Reading offset 0x300 returns the stored vector, mode, addressing mode (bit 11), level, trigger and shorthand (bits 19:18), plus the busy flag in bit 12, which is 1 from the launch until acceptance. All other bits read 0.
- R5: With shorthand 0 and bit 11 = 0 (physical), target bit n is set exactly when `core_pid` byte n equals the destination byte. The mask may be empty.
- R6: With shorthand 0 and bit 11 = 1 (logical, flat model), target bit n is set exactly when the destination byte and `core_lid` byte n share a set bit.
- R7: Shorthand 1 targets only core `self_idx`, shorthand 2 targets every core, and shorthand 3 targets every core except `self_idx`. With any of these the destination byte has no effect.
- R8: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid` stays 1 and all message fields hold their values.
- R9: When `msg_valid` and `msg_ready` are both 1 at a clock edge, `msg_valid` is 0 after that edge and the busy flag reads 0.
- R10: A low-word write while the busy flag is 1 has no effect on the message or on the stored low word.
- R11: Writes to any other offset change neither command word and launch nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDRW | Byte offset of the accessed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the offset presented in the previous cycle |
| core_pid | input | NCORE*8 | Physical ID of each core, byte n for core n |
| core_lid | input | NCORE*8 | Flat-model logical ID of each core, byte n for core n |
| self_idx | input | $clog2(NCORE) | Index of the sending core |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Receiver takes the message |
| msg_vector | output | 8 | Interrupt vector |
| msg_mode | output | 3 | Delivery mode code |
| msg_trig | output | 1 | Trigger flag |
| msg_level | output | 1 | Level flag |
| msg_targets | output | NCORE | Target mask, bit n for core n |

## Verification
The bench builds the block with its defaults: eight cores and an 8-bit ID space. This makes the full-width shorthand masks (0xFF and 0xF7 with the sender at index 3) observable. It also lets a three-core logical match and a physical destination that matches no core both be reached. The physical IDs differ from the core indices, so a compare against the index instead of the ID would show up. A launch attempt made while a message is held exercises the refusal path together with output stability.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int unsigned DEST_W = 8;

  // Byte offsets that software relies on
  localparam logic [11:0] OFF_CMD_LO = 12'h300;
  localparam logic [11:0] OFF_CMD_HI = 12'h310;

  // Shorthand codes
  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  typedef struct packed {
    logic [7:0]  vector;
    logic [2:0]  mode;
    logic        logical;
    logic        level;
    logic        trig;
    shorthand_e  sh;
  } cmd_t;

  // Unpack a low command word into its fields
  function automatic cmd_t decode_lo(input logic [31:0] w);
    cmd_t c;
    c.vector  = w[7:0];
    c.mode    = w[10:8];
    c.logical = w[11];
    c.level   = w[14];
    c.trig    = w[15];
    c.sh      = shorthand_e'(w[19:18]);
    return c;
  endfunction

  // Pack fields back into a low command word, with the busy flag at bit 12
  function automatic logic [31:0] encode_lo(input cmd_t c, input logic busy);
    return {12'h000, c.sh, 2'b00, c.trig, c.level, 1'b0, busy,
            c.logical, c.mode, c.vector};
  endfunction
endpackage

// File: rtl/ipi_target_resolve.sv
module ipi_target_resolve
  import ipi_pkg::*;
#(
  parameter int unsigned NCORE = 8,
  localparam int unsigned SELW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic [DEST_W-1:0]       dest,
  input  logic                    logical,
  input  shorthand_e              sh,
  input  logic [SELW-1:0]         self_idx,
  input  logic [NCORE*DEST_W-1:0] core_pid,
  input  logic [NCORE*DEST_W-1:0] core_lid,
  output logic [NCORE-1:0]        mask
);
  for (genvar n = 0; n < NCORE; n++) begin : g_core
    logic [DEST_W-1:0] pid_n;
    logic [DEST_W-1:0] lid_n;
    logic              is_self;
    logic              hit_addr;
    assign pid_n    = core_pid[n*DEST_W +: DEST_W];
    assign lid_n    = core_lid[n*DEST_W +: DEST_W];
    assign is_self  = (self_idx == SELW'(n));
    assign hit_addr = logical ? |(lid_n & dest) : (pid_n == dest);

    always_comb begin
      unique case (sh)
        SH_NONE:   mask[n] = hit_addr;
        SH_SELF:   mask[n] = is_self;
        SH_ALL:    mask[n] = 1'b1;
        SH_OTHERS: mask[n] = ~is_self;
        default:   mask[n] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs
  import ipi_pkg::*;
#(
  parameter int unsigned ADDRW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDRW-1:0]  addr,
  input  logic [31:0]       wdata,
  input  logic              busy,
  output logic              start,
  output cmd_t              cmd_w,
  output logic [DEST_W-1:0] dest_q,
  output logic [31:0]       rdata
);
  localparam logic [ADDRW-1:0] A_LO = ADDRW'(OFF_CMD_LO);
  localparam logic [ADDRW-1:0] A_HI = ADDRW'(OFF_CMD_HI);

  cmd_t cmd_q;
  logic hit_lo;
  logic hit_hi;
  logic unused_wbits;

  assign hit_lo       = wr && (addr == A_LO);
  assign hit_hi       = wr && (addr == A_HI);
  assign start        = hit_lo && !busy;
  assign cmd_w        = decode_lo(wdata);
  assign unused_wbits = ^{wdata[23:20], wdata[17:16], wdata[13:12]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      dest_q <= '0;
    end else begin
      if (start)  cmd_q  <= cmd_w;
      if (hit_hi) dest_q <= wdata[31:24];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (addr == A_LO) begin
      rdata <= encode_lo(cmd_q, busy);
    end else if (addr == A_HI) begin
      rdata <= {dest_q, 24'h000000};
    end else begin
      rdata <= '0;
    end
  end
endmodule

// File: rtl/ipi_msg_out.sv
module ipi_msg_out
  import ipi_pkg::*;
#(
  parameter int unsigned NCORE = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  cmd_t             cmd,
  input  logic [NCORE-1:0] mask,
  input  logic             ready,
  output logic             valid,
  output logic [7:0]       vector,
  output logic [2:0]       mode,
  output logic             trig,
  output logic             level,
  output logic [NCORE-1:0] targets
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid   <= 1'b0;
      vector  <= '0;
      mode    <= '0;
      trig    <= 1'b0;
      level   <= 1'b0;
      targets <= '0;
    end else if (start) begin
      valid   <= 1'b1;
      vector  <= cmd.vector;
      mode    <= cmd.mode;
      trig    <= cmd.trig;
      level   <= cmd.level;
      targets <= mask;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit
  import ipi_pkg::*;
#(
  parameter int unsigned NCORE = 8,
  parameter int unsigned ADDRW = 12,
  localparam int unsigned SELW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_wr,
  input  logic [ADDRW-1:0]        reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  input  logic [NCORE*DEST_W-1:0] core_pid,
  input  logic [NCORE*DEST_W-1:0] core_lid,
  input  logic [SELW-1:0]         self_idx,
  output logic                    msg_valid,
  input  logic                    msg_ready,
  output logic [7:0]              msg_vector,
  output logic [2:0]              msg_mode,
  output logic                    msg_trig,
  output logic                    msg_level,
  output logic [NCORE-1:0]        msg_targets
);
  logic              start;
  cmd_t              cmd_w;
  logic [DEST_W-1:0] dest_q;
  logic [NCORE-1:0]  mask;

  ipi_cmd_regs #(.ADDRW(ADDRW)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr    (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .busy  (msg_valid),
    .start (start),
    .cmd_w (cmd_w),
    .dest_q(dest_q),
    .rdata (reg_rdata)
  );

  ipi_target_resolve #(.NCORE(NCORE)) u_resolve (
    .dest    (dest_q),
    .logical (cmd_w.logical),
    .sh      (cmd_w.sh),
    .self_idx(self_idx),
    .core_pid(core_pid),
    .core_lid(core_lid),
    .mask    (mask)
  );

  ipi_msg_out #(.NCORE(NCORE)) u_out (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .cmd    (cmd_w),
    .mask   (mask),
    .ready  (msg_ready),
    .valid  (msg_valid),
    .vector (msg_vector),
    .mode   (msg_mode),
    .trig   (msg_trig),
    .level  (msg_level),
    .targets(msg_targets)
  );
endmodule

// File: rtl/ipi_cmd_chk.sv
module ipi_cmd_chk #(
  parameter int unsigned NCORE = 8,
  parameter int unsigned ADDRW = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic [ADDRW-1:0] reg_addr,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [7:0]       msg_vector,
  input logic [2:0]       msg_mode,
  input logic             msg_trig,
  input logic             msg_level,
  input logic [NCORE-1:0] msg_targets
);
  localparam logic [ADDRW-1:0] A_LO = ADDRW'(12'h300);

  // R3
  launch_only_after_lo_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> $past(reg_wr && (reg_addr == A_LO)));

  // R8
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_mode)
      && $stable(msg_trig) && $stable(msg_level) && $stable(msg_targets)));

  // R9
  drop_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_ready) |=> !msg_valid);

  // R10
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready && reg_wr && (reg_addr == A_LO))
      |=> ($stable(msg_vector) && $stable(msg_targets) && $stable(msg_mode)));
endmodule

bind ipi_cmd_unit ipi_cmd_chk #(.NCORE(NCORE), .ADDRW(ADDRW)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .msg_valid  (msg_valid),
  .msg_ready  (msg_ready),
  .msg_vector (msg_vector),
  .msg_mode   (msg_mode),
  .msg_trig   (msg_trig),
  .msg_level  (msg_level),
  .msg_targets(msg_targets)
);

// File: tb/test_ipi_cmd_unit.sv
module test_ipi_cmd_unit;
  localparam int NCORE = 8;
  localparam int ADDRW = 12;
  localparam logic [11:0] LO = 12'h300;
  localparam logic [11:0] HI = 12'h310;
  localparam logic [2:0] SELF = 3'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [ADDRW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NCORE*8-1:0] core_pid;
  logic [NCORE*8-1:0] core_lid;
  logic msg_valid, msg_ready = 1'b0;
  logic [7:0] msg_vector;
  logic [2:0] msg_mode;
  logic msg_trig, msg_level;
  logic [NCORE-1:0] msg_targets;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // Physical IDs 0x20+n, logical IDs one-hot per core
  initial begin
    for (int n = 0; n < NCORE; n++) begin
      core_pid[n*8 +: 8] = 8'h20 + 8'(n);
      core_lid[n*8 +: 8] = 8'(1 << n);
    end
  end

  ipi_cmd_unit #(.NCORE(NCORE), .ADDRW(ADDRW)) i_ipi_cmd_unit (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_pid(core_pid),
    .core_lid(core_lid), .self_idx(SELF), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_mode(msg_mode),
    .msg_trig(msg_trig), .msg_level(msg_level), .msg_targets(msg_targets)
  );

  function automatic logic [31:0] lo_word(input logic [7:0] vec, input logic [2:0] mode,
      input logic lg, input logic lvl, input logic trg, input logic [1:0] sh);
    return {12'h000, sh, 2'b00, trg, lvl, 1'b0, 1'b0, lg, mode, vec};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_addr = '0;
  endtask

  task automatic accept();
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  // Launch, verify message and busy flag, then accept and verify idle
  task automatic send_and_check(input string req, input logic [7:0] dest,
      input logic [31:0] lo, input logic [NCORE-1:0] exp_mask);
    logic [31:0] rd;
    wr_reg(HI, {dest, 24'h0});
    wr_reg(LO, lo);
    check("R3 valid", {31'b0, msg_valid}, 32'd1);
    check("R3 vector", {24'b0, msg_vector}, {24'b0, lo[7:0]});
    check("R3 mode", {29'b0, msg_mode}, {29'b0, lo[10:8]});
    check("R3 level/trig", {30'b0, msg_trig, msg_level}, {30'b0, lo[15], lo[14]});
    check(req, {24'b0, msg_targets}, {24'b0, exp_mask});
    rd_reg(LO, rd);
    check("R4 readback busy", rd, lo | 32'h1000);
    accept();
    check("R9 valid drop", {31'b0, msg_valid}, 32'd0);
    rd_reg(LO, rd);
    check("R9 busy clear", rd, lo);
  endtask

  task automatic t_reset();
    logic [31:0] rd;
    check("R1 valid", {31'b0, msg_valid}, 32'd0);
    rd_reg(LO, rd); check("R1 low word", rd, 32'd0);
    rd_reg(HI, rd); check("R1 high word", rd, 32'd0);
  endtask

  task automatic t_high();
    logic [31:0] rd;
    wr_reg(HI, 32'hAB00_1234);
    rd_reg(HI, rd);
    check("R2 high readback", rd, 32'hAB00_0000);
  endtask

  task automatic t_physical();
    send_and_check("R5 phys hit", 8'h25, lo_word(8'h41, 3'd0, 1'b0, 1'b1, 1'b0, 2'd0), 8'h20);
    send_and_check("R5 phys miss", 8'h99, lo_word(8'h42, 3'd4, 1'b0, 1'b1, 1'b0, 2'd0), 8'h00);
  endtask

  task automatic t_logical_hold_busy();
    logic [31:0] lo, rd;
    lo = lo_word(8'h77, 3'd5, 1'b1, 1'b0, 1'b1, 2'd0);
    wr_reg(HI, 32'h8C00_0000);
    wr_reg(LO, lo);
    check("R6 logical mask", {24'b0, msg_targets}, 32'h8C);
    repeat (3) @(negedge clk);
    check("R8 held valid", {31'b0, msg_valid}, 32'd1);
    check("R8 held targets", {24'b0, msg_targets}, 32'h8C);
    wr_reg(LO, lo_word(8'h11, 3'd6, 1'b0, 1'b1, 1'b0, 2'd2));
    check("R10 vector kept", {24'b0, msg_vector}, 32'h77);
    check("R10 targets kept", {24'b0, msg_targets}, 32'h8C);
    rd_reg(LO, rd);
    check("R10 stored word kept", rd, lo | 32'h1000);
    accept();
    check("R9 valid drop", {31'b0, msg_valid}, 32'd0);
  endtask

  task automatic t_shorthand();
    send_and_check("R7 self", 8'h25, lo_word(8'h50, 3'd0, 1'b0, 1'b1, 1'b0, 2'd1), 8'h08);
    send_and_check("R7 all", 8'h25, lo_word(8'h51, 3'd2, 1'b1, 1'b1, 1'b0, 2'd2), 8'hFF);
    send_and_check("R7 others", 8'h25, lo_word(8'h52, 3'd6, 1'b0, 1'b1, 1'b0, 2'd3), 8'hF7);
  endtask

  task automatic t_other_addr();
    logic [31:0] rd, lo_before, hi_before;
    rd_reg(LO, lo_before);
    rd_reg(HI, hi_before);
    wr_reg(12'h320, 32'hFFFF_FFFF);
    wr_reg(12'h304, 32'h000C_0F99);
    check("R11 no launch", {31'b0, msg_valid}, 32'd0);
    rd_reg(LO, rd); check("R11 low kept", rd, lo_before);
    rd_reg(HI, rd); check("R11 high kept", rd, hi_before);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_high();
    t_physical();
    t_logical_hold_busy();
    t_shorthand();
    t_other_addr();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule